// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Posted Status

This block turns an asynchronous serial line into parallel words for a processor. It samples the incoming line at sixteen times the bit rate, finds the start bit, and collects eight or nine data-plus-parity bits, least significant first. It then checks the stop bit. Each finished frame moves from an internal shift register into a receive data register that software can read. Because of this double buffer, a new frame can arrive while software still holds the previous one.

All error information for a frame is posted to a five-bit status word in the same cycle that the word reaches the data register. The error information covers line noise, parity and framing. If the data register still holds an unread word when the next frame completes, the old word is kept, the new frame is dropped, and an overrun flag is raised. Software clears the status in two steps. It first reads the status, which arms the clear. A later data read then clears all the flags. An interrupt request follows the receive-full flag while the interrupt enable is set.

The receive state machine has four states. IDLE waits for a low line on a tick (transition IDLE to START). START drops back to IDLE if the mid-bit vote is high, which rejects a glitch. Otherwise START moves to DATA at the end of the bit. DATA moves to STOP after the last configured bit. STOP posts the frame at its mid-bit vote and returns to IDLE. Clearing the enable forces any state to IDLE.

Top module: `uart_rx_status`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle, and any traffic on `rxd` leaves status and data unchanged.
- R2: The receiver counts 16 `baud_tick` pulses per bit. Each bit value is the majority of three samples taken at tick offsets 7, 8 and 9 of the bit, counted from the tick on which the start edge is seen. Data bits arrive least significant first into `data_q[0]` upward.
- R3: If the three samples of any bit (start, data or stop) disagree, the noise flag (status bit 2) is posted with that frame.
- R4: A low pulse whose mid-bit vote is high is discarded as a glitch. No frame is produced, and the next real frame is received correctly.
- R5: With `cfg_nine`=0 a frame carries 8 bits (`data_q[8]` reads 0); with `cfg_nine`=1 it carries 9. With `cfg_par_en`=1 the last of those bits is parity. The parity is even when `cfg_par_odd`=0 and odd when 1, and a mismatch posts the parity flag (status bit 3).
- R6: A stop bit voted low posts the framing flag (status bit 4). The data is still transferred.
- R7: At the mid-bit of the stop bit, if the register is free, the frame moves to `data_q`. In the same cycle receive-full (status bit 0) is set, overrun (bit 1) is cleared, and the three error flags are replaced with those of the frame.
- R8: If receive-full is set when a frame completes, `data_q` and the noise, parity and framing flags stay unchanged, the frame is dropped, and overrun (status bit 1) is set.
- R9: A pulse on `rd_stat` arms the clear. The next `rd_data` pulse clears all five flags. An `rd_data` pulse without a preceding status read clears nothing.
- R10: A clearing data read in the same cycle as a frame completion frees the register. The new frame is transferred with receive-full set and overrun clear.
- R11: `irq` is high exactly while `irq_en` and receive-full are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial input line, idle high |
| cfg_nine | input | 1 | 1: nine data-plus-parity bits, 0: eight |
| cfg_par_en | input | 1 | Last bit of the frame is parity |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| irq_en | input | 1 | Receive interrupt enable |
| rd_stat | input | 1 | Status read strobe (arms the clear) |
| rd_data | input | 1 | Data read strobe (clears if armed) |
| stat_q | output | 5 | {framing, parity, noise, overrun, full} |
| data_q | output | 9 | Receive data register |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land in the same clock cycle: the clearing data read issued by software and the completion of a new frame at the stop-bit mid-point. The bench counts the exact cycle of completion from the start edge, through the two-stage input synchronizer and the 16-tick bit counter. It then places the clearing read one cycle early, in that exact cycle, and one cycle late. The early and same-cycle reads must both leave the new word loaded with only receive-full set. The late read must find that an overrun has already kept the old word, and then clear every flag.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int DW = 9;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          noise;
        logic          perr;
        logic          ferr;
    } rx_frame_t;

    localparam int ST_FULL  = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_NOISE = 2;
    localparam int ST_PAR   = 3;
    localparam int ST_FRM   = 4;
    localparam int ST_W     = 5;

endpackage

// File: rtl/urx_sampler.sv
module urx_sampler #(
    parameter int SYNC = 2,
    parameter int OSR  = 16,
    localparam int CW  = $clog2(OSR),
    localparam int MID = OSR / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          tick,
    input  logic [CW-1:0] phase,
    output logic          rxd_s,
    output logic          vote_stb,
    output logic          vote,
    output logic          disagree
);

    logic [SYNC-1:0] chain_q;
    logic            samp_a_q;
    logic            samp_b_q;

    // input synchronizer, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[SYNC-2:0], rxd};
        end
    end

    assign rxd_s = chain_q[SYNC-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
        end else if (tick) begin
            if (phase == CW'(MID - 1)) samp_a_q <= rxd_s;
            if (phase == CW'(MID))     samp_b_q <= rxd_s;
        end
    end

    always_comb begin
        vote_stb = tick && (phase == CW'(MID + 1));
        vote     = (samp_a_q & samp_b_q) | (samp_a_q & rxd_s) | (samp_b_q & rxd_s);
        disagree = !((samp_a_q == samp_b_q) && (samp_b_q == rxd_s));
    end

    // R2
    vote_majority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vote_stb && samp_a_q && samp_b_q |-> vote);

endmodule

// File: rtl/urx_framer.sv
module urx_framer
    import urx_pkg::*;
#(
    parameter int OSR  = 16,
    localparam int CW  = $clog2(OSR),
    localparam int IW  = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          tick,
    input  logic          rxd_s,
    input  logic          vote_stb,
    input  logic          vote,
    input  logic          disagree,
    input  logic          cfg_nine,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    output logic [CW-1:0] phase,
    output logic          frame_done,
    output rx_frame_t     frame
);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] shreg_q;
    logic          par_q;
    logic          noise_q;
    logic          bit_end;
    logic [IW-1:0] last_idx;

    assign bit_end  = tick && (cnt_q == CW'(OSR - 1));
    assign last_idx = cfg_nine ? IW'(DW - 1) : IW'(DW - 2);
    assign phase    = cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  if (tick && !rxd_s) state_d = RX_START;
                RX_START: begin
                    if (vote_stb && vote) state_d = RX_IDLE;
                    else if (bit_end)     state_d = RX_DATA;
                end
                RX_DATA:  if (bit_end && idx_q == last_idx) state_d = RX_STOP;
                RX_STOP:  if (vote_stb) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    // bit counter and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            noise_q <= 1'b0;
        end else if (state_q == RX_IDLE) begin
            cnt_q   <= CW'(1);
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            noise_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + CW'(1);
            if (vote_stb) begin
                noise_q <= noise_q | disagree;
                if (state_q == RX_DATA) begin
                    shreg_q[idx_q] <= vote;
                    par_q          <= par_q ^ vote;
                end
            end
            if (bit_end && state_q == RX_DATA) idx_q <= idx_q + IW'(1);
        end
    end

    // outputs
    always_comb begin
        frame_done  = rx_en && (state_q == RX_STOP) && vote_stb;
        frame.data  = shreg_q;
        frame.noise = noise_q | disagree;
        frame.perr  = cfg_par_en & (par_q ^ cfg_par_odd);
        frame.ferr  = ~vote;
    end

    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state_q == RX_IDLE);

    // R7
    done_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> state_q == RX_IDLE);

    // R4
    glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && state_q == RX_START && vote_stb && vote |=> state_q == RX_IDLE);

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == RX_DATA |-> idx_q <= IW'(DW - 1));

endmodule

// File: rtl/urx_status.sv
module urx_status
    import urx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_done,
    input  rx_frame_t       frame,
    input  logic            rd_stat,
    input  logic            rd_data,
    input  logic            irq_en,
    output logic [ST_W-1:0] stat_o,
    output logic [DW-1:0]   data_o,
    output logic            irq
);

    logic          full_q, ovr_q, nf_q, pf_q, fe_q, armed_q;
    logic [DW-1:0] rdr_q;
    logic          clear_now, full_eff, accept, blocked;

    always_comb begin
        clear_now = rd_data && armed_q;
        full_eff  = full_q && !clear_now;
        accept    = frame_done && !full_eff;
        blocked   = frame_done && full_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_q  <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            nf_q   <= 1'b0;
            pf_q   <= 1'b0;
            fe_q   <= 1'b0;
        end else if (accept) begin
            rdr_q  <= frame.data;
            full_q <= 1'b1;
            ovr_q  <= 1'b0;
            nf_q   <= frame.noise;
            pf_q   <= frame.perr;
            fe_q   <= frame.ferr;
        end else if (blocked) begin
            ovr_q  <= 1'b1;
        end else if (clear_now) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            nf_q   <= 1'b0;
            pf_q   <= 1'b0;
            fe_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (rd_stat) armed_q <= 1'b1;
        else if (rd_data) armed_q <= 1'b0;
    end

    always_comb begin
        stat_o           = '0;
        stat_o[ST_FULL]  = full_q;
        stat_o[ST_OVR]   = ovr_q;
        stat_o[ST_NOISE] = nf_q;
        stat_o[ST_PAR]   = pf_q;
        stat_o[ST_FRM]   = fe_q;
        data_o           = rdr_q;
        irq              = irq_en & full_q;
    end

    // R8
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && full_q && !rd_data |=> $stable(rdr_q) && ovr_q);

    // R8
    no_err_with_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && full_q && !rd_data |=> $stable({nf_q, pf_q, fe_q}));

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && armed_q && !frame_done |=> stat_o == '0);

    // R7
    full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(frame_done));

    // R11
    irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> full_q);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import urx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2,
    localparam int CW  = $clog2(OSR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  logic            rx_en,
    input  logic            rxd,
    input  logic            cfg_nine,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            irq_en,
    input  logic            rd_stat,
    input  logic            rd_data,
    output logic [ST_W-1:0] stat_q,
    output logic [DW-1:0]   data_q,
    output logic            irq
);

    logic          rxd_s, vote_stb, vote, disagree, frame_done;
    logic [CW-1:0] phase;
    rx_frame_t     frame;

    urx_sampler #(.SYNC(SYNC), .OSR(OSR)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .tick     (baud_tick),
        .phase    (phase),
        .rxd_s    (rxd_s),
        .vote_stb (vote_stb),
        .vote     (vote),
        .disagree (disagree)
    );

    urx_framer #(.OSR(OSR)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .tick        (baud_tick),
        .rxd_s       (rxd_s),
        .vote_stb    (vote_stb),
        .vote        (vote),
        .disagree    (disagree),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .phase       (phase),
        .frame_done  (frame_done),
        .frame       (frame)
    );

    urx_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame      (frame),
        .rd_stat    (rd_stat),
        .rd_data    (rd_data),
        .irq_en     (irq_en),
        .stat_o     (stat_q),
        .data_o     (data_q),
        .irq        (irq)
    );

endmodule

// File: tb/tb_uart_rx_status.sv
`timescale 1ns/1ps
module tb_uart_rx_status;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b1;
    logic rx_en = 1'b0, rxd = 1'b1;
    logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic irq_en = 1'b0, rd_stat = 1'b0, rd_data = 1'b0;
    logic [4:0] stat_q;
    logic [8:0] data_q;
    logic irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    uart_rx_status dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en), .rxd(rxd),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .irq_en(irq_en), .rd_stat(rd_stat), .rd_data(rd_data),
        .stat_q(stat_q), .data_q(data_q), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int flip_at);
        for (int j = 0; j < 16; j++) begin
            rxd = (j == flip_at) ? ~v : v;
            @(negedge clk);
        end
    endtask

    // noisy: -1 none, 0 start bit, i data bit i-1
    task automatic send(input logic [8:0] w, input int n, input logic stopv, input int noisy);
        drive_bit(1'b0, noisy == 0 ? 8 : -1);
        for (int i = 0; i < n; i++) drive_bit(w[i], noisy == i + 1 ? 8 : -1);
        drive_bit(stopv, -1);
        drive_bit(1'b1, -1);
    endtask

    task automatic read_pair(output logic [4:0] s, output logic [8:0] d);
        s = stat_q;
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        d = data_q;
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic expect_frame(input string req, input logic [4:0] es, input logic [8:0] ed);
        logic [4:0] s;
        logic [8:0] d;
        read_pair(s, d);
        chk(req, "status", s, es);
        chk(req, "data", d, ed);
        chk("R9", "status after clear", stat_q, 5'b0);
    endtask

    // R10: clear with rd_data k cycles after the start edge is driven
    task automatic collide(input int k, input logic [4:0] es, input logic [8:0] ed);
        logic [4:0] s;
        logic [8:0] d;
        read_pair(s, d);
        send(9'h0C3, 8, 1'b1, -1);
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        fork
            send(9'h05A, 8, 1'b1, -1);
            begin
                repeat (k) @(negedge clk);
                rd_data = 1'b1;
                @(negedge clk);
                rd_data = 1'b0;
            end
        join
        chk("R10", $sformatf("status k=%0d", k), stat_q, es);
        chk("R10", $sformatf("data k=%0d", k), data_q, ed);
    endtask

    initial begin
        repeat (200000 - 10000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] w;
        logic p, bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7", "reset status", stat_q, 5'b0);
        chk("R7", "reset data", data_q, 9'h0);
        chk("R11", "reset irq", irq, 1'b0);

        // R1 disabled receiver ignores traffic
        send(9'h055, 8, 1'b1, -1);
        chk("R1", "status while disabled", stat_q, 5'b0);
        chk("R1", "data while disabled", data_q, 9'h0);
        rx_en = 1'b1;
        @(negedge clk);

        // R2 exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 8, 1'b1, -1);
            expect_frame("R2", 5'b00001, 9'(v));
        end

        // R5 nine-bit frames, no parity
        cfg_nine = 1'b1;
        for (int v = 0; v < 4; v++) begin
            w = (v == 0) ? 9'h1FF : (v == 1) ? 9'h100 : (v == 2) ? 9'h0AA : 9'h155;
            send(w, 9, 1'b1, -1);
            expect_frame("R5", 5'b00001, w);
        end

        // R5 eight-bit frames with parity in bit 7, both senses, some corrupted
        cfg_nine = 1'b0;
        cfg_par_en = 1'b1;
        for (int v = 0; v < 128; v++) begin
            cfg_par_odd = v[0];
            p = (^v[6:0]) ^ cfg_par_odd;
            bad = (v % 5 == 0);
            w = {1'b0, p ^ bad, 7'(v)};
            send(w, 8, 1'b1, -1);
            expect_frame("R5", bad ? 5'b01001 : 5'b00001, w);
        end

        // R5 nine-bit frames with parity in bit 8
        cfg_nine = 1'b1;
        for (int v = 0; v < 16; v++) begin
            cfg_par_odd = v[1];
            p = (^(8'(v * 37))) ^ cfg_par_odd;
            bad = (v % 3 == 0);
            w = {p ^ bad, 8'(v * 37)};
            send(w, 9, 1'b1, -1);
            expect_frame("R5", bad ? 5'b01001 : 5'b00001, w);
        end
        cfg_nine = 1'b0;
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;

        // R3 single disagreeing sample in each bit position
        for (int b = 0; b < 9; b++) begin
            send(9'h0A5, 8, 1'b1, b);
            expect_frame("R3", 5'b00101, 9'h0A5);
        end

        // R4 short low pulse is a glitch
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk("R4", "status after glitch", stat_q, 5'b0);
        send(9'h03C, 8, 1'b1, -1);
        expect_frame("R4", 5'b00001, 9'h03C);

        // R6 framing error, data still posted
        send(9'h0E1, 8, 1'b0, -1);
        repeat (20) @(negedge clk);
        expect_frame("R6", 5'b10001, 9'h0E1);

        // R8 overrun keeps old word and old flags
        send(9'h011, 8, 1'b1, -1);
        send(9'h022, 8, 1'b0, 3);
        repeat (20) @(negedge clk);
        chk("R8", "data kept", data_q, 9'h011);
        expect_frame("R8", 5'b00011, 9'h011);

        // R9 data read without status read clears nothing
        send(9'h077, 8, 1'b1, -1);
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        @(negedge clk);
        chk("R9", "unarmed read keeps status", stat_q, 5'b00001);
        expect_frame("R9", 5'b00001, 9'h077);

        // R11 interrupt follows full and enable
        irq_en = 1'b1;
        @(negedge clk);
        chk("R11", "irq empty", irq, 1'b0);
        send(9'h099, 8, 1'b1, -1);
        chk("R11", "irq full enabled", irq, 1'b1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R11", "irq full disabled", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        expect_frame("R11", 5'b00001, 9'h099);
        chk("R11", "irq after clear", irq, 1'b0);
        irq_en = 1'b0;

        // R10 clearing read around the completion cycle (16*9+11 = 155)
        collide(154, 5'b00001, 9'h05A);
        collide(155, 5'b00001, 9'h05A);
        collide(156, 5'b00000, 9'h0C3);

        // R1 disable mid-frame aborts, next frame clean
        {rd_stat, rd_data} = 2'b00;
        fork
            send(9'h0F0, 8, 1'b1, -1);
            begin
                repeat (60) @(negedge clk);
                rx_en = 1'b0;
            end
        join
        chk("R1", "aborted frame not posted", stat_q, 5'b0);
        rx_en = 1'b1;
        @(negedge clk);
        send(9'h00F, 8, 1'b1, -1);
        expect_frame("R1", 5'b00001, 9'h00F);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule